// File: doc/BRIEF.md
# Sixteen-Function Arithmetic Logic Shift Unit

This block is a purely combinational datapath unit. It takes two operand buses of `WIDTH` bits (16 by default), a 4-bit function code and a carry input, and returns a result of the same width together with four status flags: overflow, sign, zero and carry. It contains no state. A surrounding processor datapath drives the operand buses from its register multiplexers and writes the result and flags back.

Internally there are four sub-units: arithmetic, logic, right shift/rotate and left shift/rotate. All four evaluate every operand pair at all times. The upper two bits of the function code choose which sub-unit drives the result. The lower two bits choose the operation inside that sub-unit. The carry input changes the arithmetic operations by adding one, and it supplies the bit shifted in by the two rotate-through-carry operations. Subtraction is formed as A plus the inverse of B plus the carry input. With carry-in set, the carry flag after a subtraction therefore reads 1 when no borrow occurred.

Top module: `alsu16`

## Requirements
- R1: Codes 0000 and 0001 give A + Cin and A + B + Cin, truncated to WIDTH bits.
- R2: Codes 0010 and 0011 give A + ~B + Cin (A-B-1, or A-B when Cin=1) and A + all-ones + Cin (A-1, or A when Cin=1).
- R3: Codes 0100, 0101, 0110 and 0111 give A AND B, A OR B, A XOR B and NOT A.
- R4: Codes 1000..1011 move A right by one place. The bit entering the MSB is 0 for 1000, A[0] for 1001, Cin for 1010 and A[MSB] for 1011.
- R5: Codes 1100..1111 move A left by one place. The bit entering bit 0 is 0 for 1100 and 1111, A[MSB] for 1101 and Cin for 1110.
- R6: The zero flag is 1 exactly when every result bit is 0. The sign flag equals the result MSB. Both hold for every code.
- R7: The carry flag is the carry out of the MSB for codes 00xx, 0 for codes 01xx, A[0] for codes 10xx and A[MSB] for codes 11xx.
- R8: The overflow flag is two's-complement overflow of the addition actually performed for codes 00xx. For code 1111 it is A[MSB] XOR A[MSB-1]. It is 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| fsel_i | input | 4 | Function code: bits 3:2 pick the sub-unit, bits 1:0 pick the operation |
| cin_i | input | 1 | Carry input |
| res_o | output | WIDTH | Result |
| ovf_o | output | 1 | Overflow flag |
| neg_o | output | 1 | Sign flag |
| zero_o | output | 1 | Zero flag |
| cout_o | output | 1 | Carry flag |

## Verification
The bench builds two copies of the unit. The first is a 4-bit copy that is swept over every combination of both operands, all sixteen codes and both carry-in values (8192 vectors). At that width every wrap, overflow, zero result and shifted-out bit is reached exhaustively. The second is the default 16-bit copy. It is driven with boundary operands (0, 1, all-ones, 0x7FFF, 0x8000) and a pseudo-random sequence across every code and carry value, so that the full-width carry chain and the MSB-specific flags are exercised as well.

// File: rtl/alsu16_pkg.sv
// Package: shared function-code layout for the arithmetic logic shift unit.
// The upper two bits of the code select a sub-unit; the lower two select the
// operation inside it. Values are fixed because the datapath decodes them.
package alsu16_pkg;

    typedef enum logic [1:0] {
        GRP_ARITH = 2'b00,
        GRP_LOGIC = 2'b01,
        GRP_SHR   = 2'b10,
        GRP_SHL   = 2'b11
    } alsu_grp_e;

    localparam logic [3:0] FN_PASS_INC = 4'b0000;
    localparam logic [3:0] FN_ADD      = 4'b0001;
    localparam logic [3:0] FN_SUB      = 4'b0010;
    localparam logic [3:0] FN_DEC      = 4'b0011;
    localparam logic [3:0] FN_AND      = 4'b0100;
    localparam logic [3:0] FN_OR       = 4'b0101;
    localparam logic [3:0] FN_XOR      = 4'b0110;
    localparam logic [3:0] FN_NOT      = 4'b0111;
    localparam logic [3:0] FN_SHR      = 4'b1000;
    localparam logic [3:0] FN_ROR      = 4'b1001;
    localparam logic [3:0] FN_RORC     = 4'b1010;
    localparam logic [3:0] FN_ASR      = 4'b1011;
    localparam logic [3:0] FN_SHL      = 4'b1100;
    localparam logic [3:0] FN_ROL      = 4'b1101;
    localparam logic [3:0] FN_ROLC     = 4'b1110;
    localparam logic [3:0] FN_ASL      = 4'b1111;

endpackage

// File: rtl/alsu16_arith.sv
// Arithmetic sub-unit: one adder whose second operand is 0, B, ~B or all-ones,
// selected by op, plus the carry input. Reports the carry out of the MSB and
// two's-complement overflow of the addition actually performed.
// Assumes: WIDTH >= 2; purely combinational.
module alsu16_arith #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   sum;

    // Pick the second adder operand for the requested operation.
    always_comb begin
        unique case (op_i)
            2'b00:   b_eff = '0;
            2'b01:   b_eff = b_i;
            2'b10:   b_eff = ~b_i;
            default: b_eff = '1;
        endcase
    end

    // Single carry chain shared by all four arithmetic operations.
    always_comb begin
        sum    = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
        res_o  = sum[MSB:0];
        cout_o = sum[WIDTH];
        ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
    end

    // Identity checks on the pass-through encodings.
    always_comb begin
        if (op_i == 2'b00 && !cin_i)
            AST_PASS_NO_CARRY: assert (res_o == a_i && !cout_o && !ovf_o) else $error("pass A altered"); // R1
        if (op_i == 2'b11 && cin_i)
            AST_DEC_PLUS_ONE_IDENTITY: assert (res_o == a_i) else $error("A-1+1 not A"); // R2
    end

endmodule

// File: rtl/alsu16_logic.sv
// Logic sub-unit: bitwise AND, OR, XOR of A and B, or the inverse of A.
// Assumes: purely combinational; flags for this group are produced at the top.
module alsu16_logic #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] res_o
);

    // Bitwise operation chosen by op.
    always_comb begin
        unique case (op_i)
            2'b00:   res_o = a_i & b_i;
            2'b01:   res_o = a_i | b_i;
            2'b10:   res_o = a_i ^ b_i;
            default: res_o = ~a_i;
        endcase
    end

endmodule

// File: rtl/alsu16_shift.sv
// Shift/rotate sub-unit for one direction (LEFT=0: right, LEFT=1: left).
// op picks the bit that enters: 0, the wrapped bit, the carry input, or the
// arithmetic fill. The bit pushed out becomes the carry. Only an arithmetic
// left shift reports overflow (sign change).
// Assumes: WIDTH >= 2; single-place moves only.
module alsu16_shift #(
    parameter int WIDTH = 16,
    parameter bit LEFT  = 1'b0
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [1:0]       op_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic fill;

    generate
        if (LEFT) begin : g_left
            // Choose the bit entering position 0.
            always_comb begin
                unique case (op_i)
                    2'b01:   fill = a_i[MSB];
                    2'b10:   fill = cin_i;
                    default: fill = 1'b0;
                endcase
            end
            // Move left by one and report the bit leaving the MSB.
            always_comb begin
                res_o  = {a_i[MSB-1:0], fill};
                cout_o = a_i[MSB];
                ovf_o  = (op_i == 2'b11) ? (a_i[MSB] ^ a_i[MSB-1]) : 1'b0;
            end
        end else begin : g_right
            // Choose the bit entering the MSB.
            always_comb begin
                unique case (op_i)
                    2'b01:   fill = a_i[0];
                    2'b10:   fill = cin_i;
                    2'b11:   fill = a_i[MSB];
                    default: fill = 1'b0;
                endcase
            end
            // Move right by one and report the bit leaving position 0.
            always_comb begin
                res_o  = {fill, a_i[MSB:1]};
                cout_o = a_i[0];
                ovf_o  = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/alsu16.sv
// Top of the arithmetic logic shift unit. All four sub-units compute in
// parallel; fsel_i[3:2] selects which one drives the result, carry and
// overflow. Zero and sign are derived once from the selected result.
// Assumes: WIDTH >= 2; purely combinational, no clock or reset.
module alsu16
    import alsu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [3:0]       fsel_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ovf_o,
    output logic             neg_o,
    output logic             zero_o,
    output logic             cout_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] ar_res, lg_res, sr_res, sl_res;
    logic             ar_c, ar_v, sr_c, sr_v, sl_c, sl_v;
    alsu_grp_e        grp;
    logic [1:0]       op;

    assign grp = alsu_grp_e'(fsel_i[3:2]);
    assign op  = fsel_i[1:0];

    alsu16_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i(opa_i), .b_i(opb_i), .op_i(op), .cin_i(cin_i),
        .res_o(ar_res), .cout_o(ar_c), .ovf_o(ar_v)
    );

    alsu16_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i(opa_i), .b_i(opb_i), .op_i(op), .res_o(lg_res)
    );

    alsu16_shift #(.WIDTH(WIDTH), .LEFT(1'b0)) u_shr (
        .a_i(opa_i), .op_i(op), .cin_i(cin_i),
        .res_o(sr_res), .cout_o(sr_c), .ovf_o(sr_v)
    );

    alsu16_shift #(.WIDTH(WIDTH), .LEFT(1'b1)) u_shl (
        .a_i(opa_i), .op_i(op), .cin_i(cin_i),
        .res_o(sl_res), .cout_o(sl_c), .ovf_o(sl_v)
    );

    // Route the selected sub-unit's result, carry and overflow to the outputs.
    always_comb begin
        unique case (grp)
            GRP_ARITH: begin res_o = ar_res; cout_o = ar_c; ovf_o = ar_v; end
            GRP_LOGIC: begin res_o = lg_res; cout_o = 1'b0; ovf_o = 1'b0; end
            GRP_SHR:   begin res_o = sr_res; cout_o = sr_c; ovf_o = sr_v; end
            default:   begin res_o = sl_res; cout_o = sl_c; ovf_o = sl_v; end
        endcase
    end

    // Zero and sign flags from the selected result.
    always_comb begin
        zero_o = ~|res_o;
        neg_o  = res_o[MSB];
    end

    // Cross-unit consistency checks.
    always_comb begin
        if (grp == GRP_LOGIC)
            AST_LOGIC_FLAGS_CLEAR: assert (!cout_o && !ovf_o) else $error("logic flags set"); // R7
        if (fsel_i == FN_NOT)
            AST_NOT_COMPLEMENT: assert ((res_o ^ opa_i) == {WIDTH{1'b1}}) else $error("NOT wrong"); // R3
        if (fsel_i == FN_ROR)
            AST_ROR_WRAP: assert (res_o[MSB] == cout_o) else $error("ror wrap"); // R4
        if (fsel_i == FN_ROL)
            AST_ROL_WRAP: assert (res_o[0] == cout_o) else $error("rol wrap"); // R5
        if (zero_o)
            AST_ZERO_NOT_NEG: assert (!neg_o) else $error("zero and negative"); // R6
    end

endmodule

// File: tb/alsu16_tb_top.sv
// Bench: exhaustive sweep of a 4-bit copy plus corner and pseudo-random
// vectors on the default 16-bit copy, against an arithmetic reference model.
module alsu16_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // 16-bit instance
    logic [15:0] a16, b16, r16;
    logic [3:0]  f16;
    logic        c16, v16o, s16o, z16o, c16o;

    alsu16 #(.WIDTH(16)) dut_i (
        .opa_i(a16), .opb_i(b16), .fsel_i(f16), .cin_i(c16),
        .res_o(r16), .ovf_o(v16o), .neg_o(s16o), .zero_o(z16o), .cout_o(c16o)
    );

    // 4-bit instance
    logic [3:0] a4, b4, r4, f4;
    logic       c4, v4o, s4o, z4o, c4o;

    alsu16 #(.WIDTH(4)) dut_n4_i (
        .opa_i(a4), .opb_i(b4), .fsel_i(f4), .cin_i(c4),
        .res_o(r4), .ovf_o(v4o), .neg_o(s4o), .zero_o(z4o), .cout_o(c4o)
    );

    // Reference model computed from the requirements.
    task automatic model(input int w, input int sel, input int a, input int b, input int cin,
                         output int r, output int v, output int s, output int z, output int c);
        int m, msb, t, bb;
        m = (1 << w) - 1;
        msb = 1 << (w - 1);
        v = 0; c = 0; r = 0;
        if (sel < 4) begin
            case (sel)
                0: bb = 0;
                1: bb = b;
                2: bb = (~b) & m;
                default: bb = m;
            endcase
            t = a + bb + cin;
            r = t & m;
            c = (t >> w) & 1;
            v = (((a & msb) == (bb & msb)) && ((r & msb) != (a & msb))) ? 1 : 0;
        end else if (sel < 8) begin
            case (sel)
                4: r = a & b;
                5: r = a | b;
                6: r = a ^ b;
                default: r = (~a) & m;
            endcase
        end else if (sel < 12) begin
            r = a >> 1;
            c = a & 1;
            if (sel == 9 && (a & 1) != 0) r = r | msb;
            if (sel == 10 && cin != 0) r = r | msb;
            if (sel == 11) r = r | (a & msb);
        end else begin
            r = (a << 1) & m;
            c = ((a & msb) != 0) ? 1 : 0;
            if (sel == 13) r = r | c;
            if (sel == 14) r = r | cin;
            if (sel == 15) v = ((a >> (w - 1)) ^ (a >> (w - 2))) & 1;
        end
        z = (r == 0) ? 1 : 0;
        s = ((r & msb) != 0) ? 1 : 0;
    endtask

    function automatic string res_tag(input int sel);
        if (sel < 2)  return "R1";
        if (sel < 4)  return "R2";
        if (sel < 8)  return "R3";
        if (sel < 12) return "R4";
        return "R5";
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs of one instance against the model.
    task automatic check_all(input int w, input int sel, input int a, input int b, input int cin,
                             input int ar, input int av, input int as_, input int az, input int ac);
        int er, ev, es, ez, ec;
        model(w, sel, a, b, cin, er, ev, es, ez, ec);
        cmp(res_tag(sel), $sformatf("result w=%0d f=%0d a=%0h b=%0h ci=%0d", w, sel, a, b, cin), ar, er);
        cmp("R6", $sformatf("zero w=%0d f=%0d a=%0h", w, sel, a), az, ez);
        cmp("R6", $sformatf("sign w=%0d f=%0d a=%0h", w, sel, a), as_, es);
        cmp("R7", $sformatf("carry w=%0d f=%0d a=%0h b=%0h ci=%0d", w, sel, a, b, cin), ac, ec);
        cmp("R8", $sformatf("ovf w=%0d f=%0d a=%0h b=%0h ci=%0d", w, sel, a, b, cin), av, ev);
    endtask

    task automatic run16(input int sel, input int a, input int b, input int cin);
        @(negedge clk);
        f16 = 4'(sel); a16 = 16'(a); b16 = 16'(b); c16 = 1'(cin);
        #2;
        check_all(16, sel, a, b, cin, int'(r16), int'(v16o), int'(s16o), int'(z16o), int'(c16o));
    endtask

    int done = 0;

    initial begin
        int corners[5];
        logic [15:0] lfsr;
        corners = '{0, 1, 'hFFFF, 'h7FFF, 'h8000};
        a16 = '0; b16 = '0; f16 = '0; c16 = 1'b0;
        a4 = '0; b4 = '0; f4 = '0; c4 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Initial state: all-zero inputs give zero result and zero flag (R1, R6).
        @(negedge clk);
        cmp("R1", "idle result", int'(r16), 0);
        cmp("R6", "idle zero flag", int'(z16o), 1);
        // R1..R8: exhaustive 4-bit sweep.
        for (int sel = 0; sel < 16; sel++)
            for (int cin = 0; cin < 2; cin++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++) begin
                        @(negedge clk);
                        f4 = 4'(sel); a4 = 4'(a); b4 = 4'(b); c4 = 1'(cin);
                        #2;
                        check_all(4, sel, a, b, cin, int'(r4), int'(v4o), int'(s4o), int'(z4o), int'(c4o));
                    end
        // R1..R8: 16-bit corner operands on every code.
        for (int sel = 0; sel < 16; sel++)
            for (int cin = 0; cin < 2; cin++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j++)
                        run16(sel, corners[i], corners[j], cin);
        // R1..R8: 16-bit pseudo-random operands.
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            int ra, rb;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ra = int'(lfsr);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rb = int'(lfsr);
            run16(k % 16, ra, rb, (k / 16) % 2);
        end
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        int cyc = 0;
        while (done == 0 && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (done == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule